// File: doc/BRIEF.md
# Display Adapter External Register Decoder

This block is the small I/O-mapped register bank of a display controller that stays compatible with older software. A host reaches it over a byte-wide I/O bus. The bus carries a 16-bit port address, separate read and write strobes, and 8-bit write and read data. The block holds two writable registers: a miscellaneous output register and a feature control register. It also returns two read-only status registers, which it builds from live timing inputs: display enable, vertical retrace, and four sense-switch lines.

The bits of the miscellaneous output register drive configuration outputs to the rest of the controller:

- sync polarity inversion for the horizontal and vertical syncs,
- an odd/even page select,
- a 2-bit dot-clock select,
- a display-buffer decode enable,
- a flag that places the CRT controller at the monochrome (3Bxh) or colour (3Dxh) base.

The same flag moves the second status register and the feature control write port between 3BAh and 3DAh. Port 3C2h writes the miscellaneous register but reads status register 0. Every timing input passes through a two-flop synchronizer before software can see it. Read data is combinational from the registered state, so it is valid in the same cycle as the read strobe.

Top module: `disp_ext_regs`

## Requirements
- R1: While reset is asserted and just after it, both writable registers hold 00h. As a result `crtc_color`=0, `dclk_sel`=00, `ram_dec_en`=0, `page_hi`=0, and both sync inversion outputs are 0.
- R2: A write strobe at port 3C2h loads `io_wdata` into the miscellaneous register at that clock edge. A read at port 3CCh returns the stored value with bit 4 forced to 0.
- R3: Miscellaneous register fields drive outputs as follows: bit 7 `vsync_inv`, bit 6 `hsync_inv`, bit 5 `page_hi`, bits 3:2 `dclk_sel`, bit 1 `ram_dec_en`, bit 0 `crtc_color`. For `dclk_sel`, 00 selects the 25 MHz clock, 01 the 28 MHz clock, and 10/11 are passed out as external selects. A polarity bit of 1 inverts that sync.
- R4: A read at port 3C2h returns status 0. Bit 4 is the synchronized `sense_in[dclk_sel]`, and all other bits are 0.
- R5: Status 1 is read at 3BAh when `crtc_color`=0 and at 3DAh when it is 1. Bit 3 is synchronized vertical retrace, bit 0 is the inverse of synchronized display enable, and all other bits are 0.
- R6: Feature control bits 1:0 are written at the status-1 port of the current mode. They are read back at 3CAh in either mode, with bits 7:2 reading 0.
- R7: An access to the status-1 port of the other mode has no effect: a write there changes nothing, and a read there returns FFh.
- R8: A change on `de_in`, `vret_in` or `sense_in` becomes visible in the read data after exactly two rising clock edges.
- R9: `io_rdata` is FFh when `io_rd` is low or the address selects no readable register. Writes to 3CCh or 3CAh change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, sampled at the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| de_in | input | 1 | Display enable, asynchronous |
| vret_in | input | 1 | Vertical retrace, asynchronous |
| sense_in | input | 4 | Sense-switch lines, asynchronous |
| vsync_inv | output | 1 | Invert vertical sync |
| hsync_inv | output | 1 | Invert horizontal sync |
| page_hi | output | 1 | Odd/even high page select |
| dclk_sel | output | 2 | Dot-clock select |
| ram_dec_en | output | 1 | Display-buffer decode enable |
| crtc_color | output | 1 | CRT controller at colour base |

## Verification
The bench goes after port aliasing first. A design that confused the two directions of 3C2h would return the miscellaneous register where status 0 belongs. A design that ignored the mode bit would answer or accept writes at the wrong status-1 port, and a wrong-mode read would return data instead of FFh. The bench also switches modes in the same cycle as a write, and reads immediately after. This catches decode logic that uses a stale or a lookahead mode, and a synchronizer with one stage too few or too many would show status changes a cycle early or late. Finally, the bench walks every clock-select code with distinct sense patterns, which exposes a wrong sense-line selection or unused bits that do not read 0.

// File: rtl/disp_ext_pkg.sv
package disp_ext_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] PORT_MISC_WR  = 16'h03C2;
    localparam logic [ADDR_W-1:0] PORT_MISC_RD  = 16'h03CC;
    localparam logic [ADDR_W-1:0] PORT_STAT0_RD = 16'h03C2;
    localparam logic [ADDR_W-1:0] PORT_FEAT_RD  = 16'h03CA;
    localparam logic [ADDR_W-1:0] PORT_ST1_MONO = 16'h03BA;
    localparam logic [ADDR_W-1:0] PORT_ST1_COLR = 16'h03DA;

    localparam logic [DATA_W-1:0] RD_IDLE = 8'hFF;

    typedef struct packed {
        logic       vs_inv;
        logic       hs_inv;
        logic       page_hi;
        logic [1:0] dclk;
        logic       ram_en;
        logic       color;
    } misc_t;

    typedef struct packed {
        logic wr_misc;
        logic wr_feat;
        logic rd_misc;
        logic rd_feat;
        logic rd_st0;
        logic rd_st1;
    } hit_t;

    function automatic logic [DATA_W-1:0] misc_to_byte(input misc_t m);
        return {m.vs_inv, m.hs_inv, m.page_hi, 1'b0, m.dclk, m.ram_en, m.color};
    endfunction

    function automatic misc_t byte_to_misc(input logic [DATA_W-1:0] b);
        misc_t m;
        m.vs_inv  = b[7];
        m.hs_inv  = b[6];
        m.page_hi = b[5];
        m.dclk    = b[3:2];
        m.ram_en  = b[1];
        m.color   = b[0];
        return m;
    endfunction

endpackage

// File: rtl/disp_ext_sync.sv
module disp_ext_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/disp_ext_decode.sv
module disp_ext_decode
    import disp_ext_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              color_i,
    output hit_t              hit_o
);

    logic [ADDR_W-1:0] st1_port;
    logic              at_st1;

    always_comb begin
        st1_port = color_i ? PORT_ST1_COLR : PORT_ST1_MONO;
        at_st1   = (addr_i == st1_port);

        hit_o         = '0;
        hit_o.wr_misc = wr_i && (addr_i == PORT_MISC_WR);
        hit_o.wr_feat = wr_i && at_st1;
        hit_o.rd_misc = rd_i && (addr_i == PORT_MISC_RD);
        hit_o.rd_feat = rd_i && (addr_i == PORT_FEAT_RD);
        hit_o.rd_st0  = rd_i && (addr_i == PORT_STAT0_RD);
        hit_o.rd_st1  = rd_i && at_st1;
    end

endmodule

// File: rtl/disp_ext_regfile.sv
module disp_ext_regfile
    import disp_ext_pkg::*;
#(
    parameter int unsigned FEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hit_t              hit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output misc_t             misc_o,
    output logic [FEAT_W-1:0] feat_o
);

    typedef struct packed {
        misc_t             misc;
        logic [FEAT_W-1:0] feat;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hit_i.wr_misc) begin
            r_d.misc = byte_to_misc(wdata_i);
        end
        if (hit_i.wr_feat) begin
            r_d.feat = wdata_i[FEAT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign misc_o = r_q.misc;
    assign feat_o = r_q.feat;

endmodule

// File: rtl/disp_ext_regs.sv
module disp_ext_regs
    import disp_ext_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SENSE_W     = 4,
    parameter int unsigned FEAT_W      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        de_in,
    input  logic        vret_in,
    input  logic [3:0]  sense_in,
    output logic        vsync_inv,
    output logic        hsync_inv,
    output logic        page_hi,
    output logic [1:0]  dclk_sel,
    output logic        ram_dec_en,
    output logic        crtc_color
);

    localparam int unsigned STAT_W = SENSE_W + 2;
    localparam int unsigned IDX_DE = SENSE_W;
    localparam int unsigned IDX_VR = SENSE_W + 1;

    hit_t              hit;
    misc_t             misc;
    logic [FEAT_W-1:0] feat;
    logic [STAT_W-1:0] stat_raw;
    logic [STAT_W-1:0] stat_sync;
    logic              sense_sel;

    disp_ext_decode u_decode (
        .addr_i  (io_addr),
        .rd_i    (io_rd),
        .wr_i    (io_wr),
        .color_i (misc.color),
        .hit_o   (hit)
    );

    disp_ext_regfile #(
        .FEAT_W (FEAT_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .wdata_i (io_wdata),
        .misc_o  (misc),
        .feat_o  (feat)
    );

    assign stat_raw = {vret_in, de_in, sense_in};

    disp_ext_sync #(
        .WIDTH  (STAT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stat_raw),
        .sync_o  (stat_sync)
    );

    assign sense_sel = stat_sync[misc.dclk];

    always_comb begin
        io_rdata = RD_IDLE;
        if (hit.rd_misc) begin
            io_rdata = misc_to_byte(misc);
        end else if (hit.rd_feat) begin
            io_rdata = '0;
            io_rdata[FEAT_W-1:0] = feat;
        end else if (hit.rd_st0) begin
            io_rdata = {3'b000, sense_sel, 4'b0000};
        end else if (hit.rd_st1) begin
            io_rdata = {4'b0000, stat_sync[IDX_VR], 2'b00, ~stat_sync[IDX_DE]};
        end
    end

    assign vsync_inv  = misc.vs_inv;
    assign hsync_inv  = misc.hs_inv;
    assign page_hi    = misc.page_hi;
    assign dclk_sel   = misc.dclk;
    assign ram_dec_en = misc.ram_en;
    assign crtc_color = misc.color;

endmodule

// File: rtl/disp_ext_regs_chk.sv
module disp_ext_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        de_in,
    input logic        vret_in,
    input logic        vsync_inv,
    input logic        hsync_inv,
    input logic        page_hi,
    input logic [1:0]  dclk_sel,
    input logic        ram_dec_en,
    input logic        crtc_color
);

    logic [7:0] outs;
    logic [1:0] since_rst;
    logic       wrong_st1;

    assign outs = {vsync_inv, hsync_inv, page_hi, 1'b0, dclk_sel, ram_dec_en, crtc_color};
    assign wrong_st1 = (io_addr == (crtc_color ? 16'h03BA : 16'h03DA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> outs == 8'h00);

    a_r2_misc_load: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03C2) |=> outs == ($past(io_wdata) & 8'hEF));

    a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == 16'h03C2) |=> $stable(outs));

    a_r7_wrong_mode_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && wrong_st1) |-> io_rdata == 8'hFF);

    a_r6_feat_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == 16'h03CA) |-> io_rdata[7:2] == 6'd0);

    a_r4_stat0_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == 16'h03C2) |-> (io_rdata & 8'hEF) == 8'h00);

    a_r8_stat1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && io_rd && !wrong_st1 &&
         (io_addr == 16'h03BA || io_addr == 16'h03DA))
        |-> io_rdata == {4'b0000, $past(vret_in, 2), 2'b00, ~$past(de_in, 2)});

    a_r9_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'hFF);

endmodule

bind disp_ext_regs disp_ext_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .de_in      (de_in),
    .vret_in    (vret_in),
    .vsync_inv  (vsync_inv),
    .hsync_inv  (hsync_inv),
    .page_hi    (page_hi),
    .dclk_sel   (dclk_sel),
    .ram_dec_en (ram_dec_en),
    .crtc_color (crtc_color)
);

// File: tb/disp_ext_regs_bench.sv
module disp_ext_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        de_in = 1'b1;
    logic        vret_in = 1'b0;
    logic [3:0]  sense_in = 4'h0;
    logic        vsync_inv, hsync_inv, page_hi, ram_dec_en, crtc_color;
    logic [1:0]  dclk_sel;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    disp_ext_regs u_disp_ext_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .de_in      (de_in),
        .vret_in    (vret_in),
        .sense_in   (sense_in),
        .vsync_inv  (vsync_inv),
        .hsync_inv  (hsync_inv),
        .page_hi    (page_hi),
        .dclk_sel   (dclk_sel),
        .ram_dec_en (ram_dec_en),
        .crtc_color (crtc_color)
    );

    // Behavioural reference: stored bytes plus a history queue of raw status inputs.
    logic [7:0] m_misc = 8'h00;
    logic [7:0] m_feat = 8'h00;
    logic [5:0] hist[$];   // {vret, de, sense}, newest at back

    function automatic logic [5:0] seen();
        if (hist.size() < 2) return 6'd0;
        return hist[hist.size()-2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_misc = 8'h00;
            m_feat = 8'h00;
            hist.delete();
        end else begin
            if (io_wr && io_addr == 16'h03C2) m_misc = io_wdata & 8'hEF;
            else if (io_wr && io_addr == (m_misc[0] ? 16'h03DA : 16'h03BA)) m_feat = io_wdata & 8'h03;
            hist.push_back({vret_in, de_in, sense_in});
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    function automatic logic [7:0] exp_rdata();
        logic [5:0] s;
        s = seen();
        if (!io_rd) return 8'hFF;
        if (io_addr == 16'h03CC) return m_misc;
        if (io_addr == 16'h03CA) return m_feat;
        if (io_addr == 16'h03C2) return {3'b000, s[m_misc[3:2]], 4'b0000};
        if (io_addr == (m_misc[0] ? 16'h03DA : 16'h03BA)) return {4'b0000, s[5], 2'b00, ~s[4]};
        return 8'hFF;
    endfunction

    function automatic string rd_tag();
        if (!rst_n) return "R1";
        if (!io_rd) return "R9";
        if (io_addr == 16'h03CC) return "R2";
        if (io_addr == 16'h03C2) return "R4";
        if (io_addr == 16'h03CA) return "R6";
        if (io_addr == (m_misc[0] ? 16'h03DA : 16'h03BA)) return "R5";
        if (io_addr == 16'h03BA || io_addr == 16'h03DA) return "R7";
        return "R9";
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(rd_tag(), io_rdata, exp_rdata());
            chk(rst_n ? "R3" : "R1",
                {vsync_inv, hsync_inv, page_hi, 1'b0, dclk_sel, ram_dec_en, crtc_color}, m_misc);
        end
    end

    task automatic step(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
        @(posedge clk);
        #2;
        io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    endtask

    task automatic wr_cyc(input logic [15:0] a, input logic [7:0] d);
        step(a, 1'b0, 1'b1, d);
    endtask

    task automatic rd_cyc(input logic [15:0] a);
        step(a, 1'b1, 1'b0, 8'h00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d misompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        rd_cyc(16'h03CC);
        rd_cyc(16'h03BA);
        rd_cyc(16'h03DA);          // R7: colour port while mono
        // R2/R3: misc write and readback, bit 4 masked
        wr_cyc(16'h03C2, 8'hF3);
        rd_cyc(16'h03CC);
        rd_cyc(16'h03DA);          // R5: now colour
        rd_cyc(16'h03BA);          // R7
        wr_cyc(16'h03BA, 8'h03);   // R7: ignored in colour
        rd_cyc(16'h03CA);
        wr_cyc(16'h03DA, 8'hFD);   // R6
        rd_cyc(16'h03CA);
        wr_cyc(16'h03CC, 8'h55);   // R9: read-only port
        wr_cyc(16'h03CA, 8'h02);   // R9
        rd_cyc(16'h03CC);
        rd_cyc(16'h03CA);
        // R3/R4: every clock code with distinct sense patterns
        for (int c = 0; c < 4; c++) begin
            wr_cyc(16'h03C2, 8'(c << 2));
            for (int p = 0; p < 16; p++) begin
                sense_in = 4'(p);
                rd_cyc(16'h03C2);
                rd_cyc(16'h03C2);
                rd_cyc(16'h03C2);
            end
        end
        // R6: mono feature write
        wr_cyc(16'h03C2, 8'h00);
        wr_cyc(16'h03BA, 8'hFE);
        rd_cyc(16'h03CA);
        wr_cyc(16'h03DA, 8'h01);   // R7 ignored in mono
        rd_cyc(16'h03CA);
        // R8: status latency, read on each of the following cycles
        de_in = 1'b0; vret_in = 1'b1;
        rd_cyc(16'h03BA);
        rd_cyc(16'h03BA);
        rd_cyc(16'h03BA);
        de_in = 1'b1; vret_in = 1'b0;
        rd_cyc(16'h03BA);
        rd_cyc(16'h03BA);
        rd_cyc(16'h03BA);
        // mode switch with immediate status access
        wr_cyc(16'h03C2, 8'h01);
        rd_cyc(16'h03DA);
        wr_cyc(16'h03C2, 8'h00);
        rd_cyc(16'h03DA);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [2:0]  sel;
            sel = 3'($urandom_range(0, 7));
            case (sel)
                3'd0: a = 16'h03C2;
                3'd1: a = 16'h03CC;
                3'd2: a = 16'h03CA;
                3'd3: a = 16'h03BA;
                3'd4: a = 16'h03DA;
                3'd5: a = 16'h03D4;
                3'd6: a = 16'h13C2;
                default: a = 16'h03BA;
            endcase
            de_in    = 1'($urandom);
            vret_in  = 1'($urandom);
            sense_in = 4'($urandom);
            step(a, 1'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom));
        end
        step(16'h0000, 1'b0, 1'b0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule